// File: doc/BRIEF.md
# FIFO-to-Byte-Stream Data Engine

This block sits between a host register port and a byte-wide card data port. It moves a transfer of up to 65535 bytes through a 16-entry, 32-bit word FIFO. In the card-to-FIFO direction (receive), bytes from the card are packed into words and pushed for the host to pop. In the FIFO-to-card direction (transmit), words pushed by the host are split into bytes and sent to the card.

Software programs a byte length and then writes the control register with the enable bit set. It watches the status word for FIFO level flags and for the completion flags. The engine turns itself off once the byte countdown and the FIFO are both empty.

In the receive direction, a host pop pauses further filling until the host next reads the status or word-count register. This stops fresh data from arriving while a driver is part-way through reading out a burst.

Top module: `fifo_byte_engine`

## Requirements
- R1: After reset, every register reads zero: length (word address 0), control (1), byte count (2), status (3) and word count (4). Both card strobes are low.
- R2: A control write stores bits 3:0, where bit 0 is enable, bit 1 is direction (1 = receive), bit 2 is mode and bit 3 is DMA enable. If bit 0 is set, the write also loads the byte counter from the 16-bit length. If bit 0 is clear, the counter is left unchanged.
- R3: In receive, successive card bytes fill a word at bits 7:0, then 15:8, then 23:16, then 31:24. A final partial word is pushed with its unfilled upper bytes set to zero. Host reads in the FIFO window (word addresses 32 to 47) pop words in the order they were pushed.
- R4: In receive, a byte is taken (`card_take_o`) only when the card is ready, the counter is nonzero and the FIFO is not full. At most one byte moves on the card port per clock.
- R5: In transmit, each popped word is sent lowest byte first, one byte per clock. The counter drops by one for each byte sent, and bytes of the last word beyond the count are discarded.
- R6: While enabled with a zero counter, status bits 8 (data end) and 10 (block end) are set and remain set. They are cleared by the next control write that has bit 0 set.
- R7: When the counter and the FIFO are both empty, the enable bit clears by itself and status bits 21:12 read zero.
- R8: While active, flags come from the FIFO level. Receive drives bit 13 (active), 15 (level >= 8), 17 (full), 19 (empty) and 21 (level > 0). Transmit drives bit 12 (active), 14 (level <= 8), 16 (full), 18 (empty) and 20 (level > 0). The group of the other direction reads zero.
- R9: The word-count register (address 4) reads (counter + 3) >> 2.
- R10: After a host pop, receive filling stops until the host reads status or word count. That read lets filling resume.
- R11: A host FIFO-window write is ignored when the counter is zero or the direction is receive. A FIFO-window read returns zero and changes nothing when the FIFO is empty or the direction is transmit, and it does not start the R10 hold.
- R12: A pushed word can be popped on the next clock. A push and a pop in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 6 | Word address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| card_rdy_i | input | 1 | Card has a receive byte ready |
| card_rdata_i | input | 8 | Receive byte from the card |
| card_take_o | output | 1 | Receive byte is consumed at this clock edge |
| card_wdata_o | output | 8 | Transmit byte to the card |
| card_put_o | output | 1 | Transmit byte is valid at this clock edge |

## Verification
In receive, the packer can push a completed word in the same cycle that the host pops the head word. This also means a refill of the slot freed by a pop can line up with the status read that releases the hold. The bench forces this by keeping the card always ready while it pops and polls status in tight loops. It then checks that every popped word matches the bytes the card delivered, packed little-endian, with nothing lost or repeated. In transmit, host pushes overlap the engine's own pops of the head word, and the bytes captured at the card port are compared against the words pushed.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
  localparam int unsigned REG_LEN  = 0;
  localparam int unsigned REG_CTRL = 1;
  localparam int unsigned REG_CNT  = 2;
  localparam int unsigned REG_STAT = 3;
  localparam int unsigned REG_WCNT = 4;
  localparam int unsigned WIN_BASE = 32;

  localparam int unsigned CTRL_W = 4;
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_RX   = 1;

  localparam int unsigned S_END     = 8;
  localparam int unsigned S_BLK_END = 10;
  localparam int unsigned S_TX_ACT  = 12;
  localparam int unsigned S_RX_ACT  = 13;
  localparam int unsigned S_TX_HE   = 14;
  localparam int unsigned S_RX_HF   = 15;
  localparam int unsigned S_TX_FULL = 16;
  localparam int unsigned S_RX_FULL = 17;
  localparam int unsigned S_TX_EMP  = 18;
  localparam int unsigned S_RX_EMP  = 19;
  localparam int unsigned S_TX_AVL  = 20;
  localparam int unsigned S_RX_AVL  = 21;

  typedef struct packed {
    logic len_wr;
    logic ctrl_wr;
    logic win_wr;
    logic win_rd;
    logic stat_rd;
    logic wcnt_rd;
  } host_op_t;
endpackage

// File: rtl/fbe_word_fifo.sv
module fbe_word_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [W-1:0]               wdata_i,
  output logic [W-1:0]               rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       empty_o,
  output logic                       full_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q;
  logic [CW-1:0] lvl_q;
  logic [PW-1:0] wr_idx;

  assign wr_idx  = rd_q + lvl_q[PW-1:0];
  assign rdata_o = mem_q[rd_q];
  assign level_o = lvl_q;
  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      lvl_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (push_i) mem_q[wr_idx] <= wdata_i;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r11_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r12_level_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(level_o));
  a_r12_next_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && empty_o) |=> (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/fbe_rx_pack.sv
module fbe_rx_pack #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         take_i,
  input  logic         last_i,
  input  logic [7:0]   byte_i,
  output logic         push_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned NB = W / 8;
  localparam int unsigned IW = $clog2(NB);

  logic [IW-1:0] idx_q;
  logic [W-1:0]  acc_q;

  always_comb begin
    word_o = acc_q;
    word_o[idx_q*8 +: 8] = byte_i;
  end

  assign push_o = take_i && ((idx_q == IW'(NB-1)) || last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (clear_i || push_o) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (take_i) begin
      idx_q <= idx_q + 1'b1;
      acc_q <= word_o;
    end
  end
endmodule

// File: rtl/fbe_tx_unpack.sv
module fbe_tx_unpack #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         put_i,
  input  logic         last_i,
  input  logic [W-1:0] head_i,
  output logic [7:0]   byte_o,
  output logic         pop_o,
  output logic         mid_o
);
  localparam int unsigned NB = W / 8;
  localparam int unsigned IW = $clog2(NB);

  logic [IW-1:0] idx_q;
  logic [W-1:0]  sh_q;

  assign mid_o  = (idx_q != '0);
  assign pop_o  = put_i && !mid_o;
  assign byte_o = mid_o ? sh_q[idx_q*8 +: 8] : head_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      idx_q <= '0;
    end else if (put_i) begin
      if (!mid_o) sh_q <= head_i;
      idx_q <= last_i ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/fbe_flags.sv
module fbe_flags #(
  parameter int unsigned DEPTH = 16
) (
  input  logic [$clog2(DEPTH+1)-1:0] level_i,
  input  logic                       active_i,
  input  logic                       rx_i,
  output logic [31:0]                flags_o
);
  import fbe_pkg::*;
  localparam int unsigned CW   = $clog2(DEPTH+1);
  localparam int unsigned HALF = DEPTH / 2;

  logic emp, ful, lo_half, hi_half;
  assign emp     = (level_i == '0);
  assign ful     = (level_i == CW'(DEPTH));
  assign lo_half = (level_i <= CW'(HALF));
  assign hi_half = (level_i >= CW'(HALF));

  always_comb begin
    flags_o = '0;
    if (active_i) begin
      if (rx_i) begin
        flags_o[S_RX_ACT]  = 1'b1;
        flags_o[S_RX_HF]   = hi_half;
        flags_o[S_RX_FULL] = ful;
        flags_o[S_RX_EMP]  = emp;
        flags_o[S_RX_AVL]  = !emp;
      end else begin
        flags_o[S_TX_ACT]  = 1'b1;
        flags_o[S_TX_HE]   = lo_half;
        flags_o[S_TX_FULL] = ful;
        flags_o[S_TX_EMP]  = emp;
        flags_o[S_TX_AVL]  = !emp;
      end
    end
  end
endmodule

// File: rtl/fifo_byte_engine.sv
module fifo_byte_engine #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  input  logic              card_rdy_i,
  input  logic [7:0]        card_rdata_i,
  output logic              card_take_o,
  output logic [7:0]        card_wdata_o,
  output logic              card_put_o
);
  import fbe_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH+1);

  host_op_t            op;
  logic                in_win;
  logic [LEN_W-1:0]    len_q, cnt_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                hold_q, end_q;
  logic                en, rx, cnt_zero, cnt_last;
  logic                fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [WORD_W-1:0]   fifo_wdata, fifo_head;
  logic [CW-1:0]       fifo_level;
  logic                host_push, host_pop;
  logic                rx_push, tx_pop, tx_mid;
  logic [WORD_W-1:0]   rx_word;
  logic [31:0]         flags_w, status_w;
  logic [LEN_W:0]      wcnt_w;
  logic                active;

  assign in_win = (host_addr_i >= ADDR_W'(WIN_BASE)) &&
                  (host_addr_i <  ADDR_W'(WIN_BASE + DEPTH));

  always_comb begin
    op = '0;
    if (host_req_i) begin
      op.len_wr  = host_we_i  && (host_addr_i == ADDR_W'(REG_LEN));
      op.ctrl_wr = host_we_i  && (host_addr_i == ADDR_W'(REG_CTRL));
      op.win_wr  = host_we_i  && in_win;
      op.win_rd  = !host_we_i && in_win;
      op.stat_rd = !host_we_i && (host_addr_i == ADDR_W'(REG_STAT));
      op.wcnt_rd = !host_we_i && (host_addr_i == ADDR_W'(REG_WCNT));
    end
  end

  assign en       = ctrl_q[C_EN];
  assign rx       = ctrl_q[C_RX];
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == LEN_W'(1));

  assign card_take_o = en && rx && !cnt_zero && card_rdy_i && !hold_q && !fifo_full;
  assign card_put_o  = en && !rx && !cnt_zero && (tx_mid || !fifo_empty);

  assign host_push  = op.win_wr && !rx && !cnt_zero && !fifo_full;
  assign host_pop   = op.win_rd && rx && !fifo_empty;
  assign fifo_push  = host_push || rx_push;
  assign fifo_pop   = host_pop || tx_pop;
  assign fifo_wdata = rx ? rx_word : host_wdata_i[WORD_W-1:0];

  fbe_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(fifo_push), .pop_i(fifo_pop), .wdata_i(fifo_wdata),
    .rdata_o(fifo_head), .level_o(fifo_level),
    .empty_o(fifo_empty), .full_o(fifo_full)
  );

  fbe_rx_pack #(.W(WORD_W)) u_rx (
    .clk_i, .rst_ni,
    .clear_i(op.ctrl_wr), .take_i(card_take_o), .last_i(cnt_last),
    .byte_i(card_rdata_i), .push_o(rx_push), .word_o(rx_word)
  );

  fbe_tx_unpack #(.W(WORD_W)) u_tx (
    .clk_i, .rst_ni,
    .clear_i(op.ctrl_wr), .put_i(card_put_o), .last_i(cnt_last),
    .head_i(fifo_head), .byte_o(card_wdata_o), .pop_o(tx_pop), .mid_o(tx_mid)
  );

  assign active = en && !(cnt_zero && fifo_empty);

  fbe_flags #(.DEPTH(DEPTH)) u_flags (
    .level_i(fifo_level), .active_i(active), .rx_i(rx), .flags_o(flags_w)
  );

  always_comb begin
    status_w            = flags_w;
    status_w[S_END]     = end_q;
    status_w[S_BLK_END] = end_q;
  end

  assign wcnt_w = ({1'b0, cnt_q} + (LEN_W+1)'(3)) >> 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      if (op.len_wr) len_q <= host_wdata_i[LEN_W-1:0];

      if (op.ctrl_wr) ctrl_q <= host_wdata_i[CTRL_W-1:0];
      else if (en && cnt_zero && fifo_empty) ctrl_q[C_EN] <= 1'b0;

      if (op.ctrl_wr && host_wdata_i[C_EN]) cnt_q <= len_q;
      else if (card_take_o || card_put_o)   cnt_q <= cnt_q - 1'b1;

      if (host_pop) hold_q <= 1'b1;
      else if (op.stat_rd || op.wcnt_rd || op.ctrl_wr) hold_q <= 1'b0;

      if (op.ctrl_wr && host_wdata_i[C_EN]) end_q <= 1'b0;
      else if (en && cnt_zero)              end_q <= 1'b1;
    end
  end

  always_comb begin
    host_rdata_o = '0;
    if (host_req_i && !host_we_i) begin
      if (host_addr_i == ADDR_W'(REG_LEN))       host_rdata_o[LEN_W-1:0]  = len_q;
      else if (host_addr_i == ADDR_W'(REG_CTRL)) host_rdata_o[CTRL_W-1:0] = ctrl_q;
      else if (host_addr_i == ADDR_W'(REG_CNT))  host_rdata_o[LEN_W-1:0]  = cnt_q;
      else if (host_addr_i == ADDR_W'(REG_STAT)) host_rdata_o             = status_w;
      else if (host_addr_i == ADDR_W'(REG_WCNT)) host_rdata_o[LEN_W:0]    = wcnt_w;
      else if (host_pop)                         host_rdata_o[WORD_W-1:0] = fifo_head;
    end
  end

  a_r4_one_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({card_take_o, card_put_o}));
  a_r10_pop_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_pop |=> !card_take_o);
  a_r5_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_put_o && !op.ctrl_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.ctrl_wr && host_wdata_i[C_EN]) |=> (cnt_q == $past(len_q)));
  a_r6_end_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && cnt_zero && !op.ctrl_wr) |=> end_q);
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (status_w[21:12] == '0));
endmodule

// File: tb/tb_fifo_byte_engine.sv
module tb_fifo_byte_engine;
  localparam int PERIOD = 10;
  localparam int A_LEN = 0, A_CTRL = 1, A_CNT = 2, A_STAT = 3, A_WCNT = 4, A_WIN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic card_rdy = 1'b0;
  logic [7:0] card_rdata = '0;
  logic card_take, card_put;
  logic [7:0] card_wdata;

  int total = 0, bad = 0;
  logic [7:0] src [1024];
  logic [7:0] dst [1024];
  logic [31:0] twd [64];
  int sp = 0, dp = 0, rdy_mode = 0;

  always #(PERIOD/2) clk = ~clk;

  fifo_byte_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata),
    .card_rdy_i(card_rdy), .card_rdata_i(card_rdata), .card_take_o(card_take),
    .card_wdata_o(card_wdata), .card_put_o(card_put)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a[5:0]; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a[5:0];
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_rx(int st, int len, int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < len) w[8*j +: 8] = src[(st + 4*k + j) % 1024];
    return w;
  endfunction

  task automatic drain_rx(int st, int len, int got_in);
    int words = (len + 3) / 4;
    int got = got_in;
    int guard = 0;
    logic [31:0] s, w;
    while (got < words && guard < 20000) begin
      guard++;
      rd(A_STAT, s);
      if (s[21]) begin
        rd(A_WIN, w);
        chk("R3 rx word order and packing", w, exp_rx(st, len, got));
        got++;
      end
    end
    chk("R4 rx word total", got, words);
    idle(2);
    rd(A_STAT, s); chk("R6 R7 end status after rx", s, 32'h500);
    rd(A_CTRL, s); chk("R7 enable cleared after rx", s & 32'h1, 32'h0);
  endtask

  task automatic run_rx(int len);
    int st;
    wr(A_LEN, len);
    st = sp;
    wr(A_CTRL, 3);
    drain_rx(st, len, 0);
  endtask

  task automatic run_tx(int len);
    int ds, words, guard;
    logic [31:0] s;
    words = (len + 3) / 4;
    wr(A_LEN, len);
    wr(A_CTRL, 1);
    rd(A_STAT, s); chk("R8 tx flags on empty fifo", s, 32'h45000);
    rd(A_CNT, s);  chk("R2 counter loaded", s, len);
    rd(A_WCNT, s); chk("R9 word count", s, words);
    ds = dp;
    for (int k = 0; k < words; k++) begin
      twd[k] = $urandom;
      guard = 0;
      do begin rd(A_STAT, s); guard++; end while (s[16] && guard < 1000);
      wr(A_WIN, twd[k]);
    end
    guard = 0;
    do begin rd(A_CTRL, s); guard++; end while (s[0] && guard < 2000);
    chk("R7 enable cleared after tx", s & 32'h1, 32'h0);
    rd(A_CNT, s); chk("R5 counter drained", s, 0);
    chk("R5 byte total", (dp - ds + 1024) % 1024, len);
    for (int i = 0; i < len; i++)
      chk("R5 tx byte order", dst[(ds + i) % 1024], (twd[i/4] >> (8*(i%4))) & 32'hff);
    rd(A_STAT, s); chk("R6 end status after tx", s, 32'h500);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      card_rdy = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'($urandom % 2) : 1'b0;
      card_rdata = src[sp];
      #2;
      if (card_take) sp = (sp + 1) % 1024;
      if (card_put) begin
        dst[dp] = card_wdata;
        dp = (dp + 1) % 1024;
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s, w;
    int st;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) src[i] = 8'($urandom);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_LEN, s);  chk("R1 length", s, 0);
    rd(A_CTRL, s); chk("R1 control", s, 0);
    rd(A_CNT, s);  chk("R1 count", s, 0);
    rd(A_STAT, s); chk("R1 status", s, 0);
    rd(A_WCNT, s); chk("R1 word count", s, 0);
    chk("R1 card strobes", {card_take, card_put}, 0);

    // R2 control without enable keeps counter
    wr(A_LEN, 9);
    wr(A_CTRL, 12);
    rd(A_CTRL, s); chk("R2 control bits stored", s, 12);
    rd(A_CNT, s);  chk("R2 no load without enable", s, 0);

    // R4 R8 R9 R10 full fifo then hold
    rdy_mode = 1;
    wr(A_LEN, 72);
    st = sp;
    wr(A_CTRL, 3);
    idle(100);
    rd(A_STAT, s); chk("R8 rx full flags", s, 32'h22A000);
    rd(A_CNT, s);  chk("R4 stop on full", s, 8);
    rd(A_WCNT, s); chk("R9 word count rounding", s, 2);
    chk("R4 bytes taken", (sp - st + 1024) % 1024, 64);
    rd(A_WIN, w);  chk("R3 first word", w, exp_rx(st, 72, 0));
    idle(20);
    rd(A_CNT, s);  chk("R10 held after pop", s, 8);
    rd(A_STAT, s); chk("R8 rx level 15 flags", s, 32'h20A000);
    idle(20);
    rd(A_CNT, s);  chk("R10 resumed after status read", s, 4);
    drain_rx(st, 72, 1);

    // R4 card not ready; R11 empty read
    rdy_mode = 0;
    wr(A_LEN, 5);
    st = sp;
    wr(A_CTRL, 3);
    idle(5);
    rd(A_STAT, s); chk("R4 R8 rx empty flags", s, 32'h82000);
    rd(A_CNT, s);  chk("R4 no take when not ready", s, 5);
    rd(A_WCNT, s); chk("R9 word count 5 bytes", s, 2);
    rd(A_WIN, w);  chk("R11 empty read zero", w, 0);
    rd(A_CNT, s);  chk("R11 empty read no change", s, 5);
    rdy_mode = 1;
    idle(10);
    rd(A_CNT, s);  chk("R11 empty read sets no hold", s, 0);
    drain_rx(st, 5, 0);

    // R11 ignored writes, R6 end cleared
    rdy_mode = 0;
    wr(A_WIN, 32'hDEADBEEF);
    wr(A_LEN, 4);
    wr(A_CTRL, 3);
    rd(A_STAT, s); chk("R11 R6 write at zero count ignored, end cleared", s, 32'h82000);
    wr(A_WIN, 32'h12345678);
    rd(A_STAT, s); chk("R11 rx-direction write ignored", s, 32'h82000);
    st = sp;
    rdy_mode = 1;
    drain_rx(st, 4, 0);

    // R5 R12 directed transmit
    run_tx(8);
    run_tx(7);
    run_tx(70);

    // R3 R12 mixed random
    for (int it = 0; it < 14; it++) begin
      if ($urandom % 2 == 0) begin
        rdy_mode = 1 + int'($urandom % 2);
        run_rx(int'($urandom % 81));
      end else begin
        run_tx(1 + int'($urandom % 80));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule